// File: doc/BRIEF.md
# Response Frame Formatter

This block sits between a command engine and the transmit side of a bus target. When the engine finishes an operation, it raises a one-cycle completion strobe together with the operation type, an error flag, an error code and the length field from the command. Before that strobe, for a read, the engine has already filled a small byte buffer with the data it fetched. The formatter then arms a response, pulses a flush output so the transmit path drops any stale queued bytes, and from then on hands out one response byte for each transmit request.

The response starts with a control byte that carries the error flag in bit 7, a zero in bit 6 and a length-minus-one field in bits 5:0. The data section follows, and its content depends on the outcome. A successful read returns the buffered data. A successful write returns one acknowledge byte whose value is a parameter. A failed operation returns one error code and forces the length field to zero. Requests made with no armed response, or after the response has been fully sent, return an idle filler byte. A start condition seen on the bus disarms the response.

Top module: `rsp_framer`

## Requirements
- R1: The first byte returned after a response is armed is the control byte: bit 7 = error flag (1 = error), bit 6 = 0, bits 5:0 = length minus one.
- R2: On success the control byte's bits 5:0 equal the length field `eng_len` given with the completion strobe.
- R3: On error the control byte is 0x80 (length field 0), and the only data byte is `eng_err_code`, whatever the operation type.
- R4: A successful write (`eng_is_write` = 1) returns exactly one data byte equal to parameter ACK_CODE (default 0xAC).
- R5: A successful read returns `eng_len`+1 data bytes, taken from buffer entries 0, 1, 2 ... `eng_len` in that order.
- R6: A transmit request made while no response is armed, or after the last byte of the response, returns 0xFF.
- R7: `tx_flush` is high for exactly the cycle after each completion strobe, which is the cycle in which the armed response first becomes visible.
- R8: `rsp_ready` goes high the cycle after a completion strobe and low the cycle after `start_seen`. If both arrive in the same cycle, the completion strobe wins.
- R9: `tx_byte` is a register. It changes only in the cycle after a transmit request, or to 0xFF the cycle after a completion strobe, and it holds its value otherwise.
- R10: Transmit requests on consecutive cycles each receive the next byte, with no gap cycles needed.
- R11: While reset is high, `tx_byte` = 0xFF, `rsp_ready` = 0 and `tx_flush` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eng_done | input | 1 | One-cycle completion strobe from the command engine |
| eng_is_write | input | 1 | Operation type at completion: 1 = write, 0 = read |
| eng_err | input | 1 | Operation failed |
| eng_err_code | input | 8 | Error code returned on failure |
| eng_len | input | LEN_W (6) | Command length field (length minus one) |
| buf_we | input | 1 | Read-data buffer write enable |
| buf_addr | input | LEN_W (6) | Read-data buffer write index |
| buf_wdata | input | 8 | Read-data buffer write byte |
| start_seen | input | 1 | Start condition observed on the bus |
| tx_req | input | 1 | Transmit side asks for the next byte |
| tx_byte | output | 8 | Registered response byte |
| tx_flush | output | 1 | Pulse: discard stale queued transmit bytes |
| rsp_ready | output | 1 | A response is armed |

## Verification
The hardest situations to reach from the ports are the ones where control events collide with byte delivery. These include a new completion strobe arriving while an earlier read response is only partly sent, a start condition and a completion strobe in the same cycle, and a transmit request in the same cycle as a start condition. Directed sequences produce each of these collisions on purpose. The directed sequences also cover a full 64-byte read delivered with requests on every cycle, and a one-byte read. After that, a long pseudo-random phase mixes requests, start conditions, completions of all three kinds and buffer refills, with refills made only while no response is armed. A behavioural queue model predicts every output on every cycle.

// File: rtl/rsp_framer_pkg.sv
package rsp_framer_pkg;
  typedef enum logic [1:0] {
    PH_HDR   = 2'd0,
    PH_BODY  = 2'd1,
    PH_SPENT = 2'd2
  } phase_t;

  typedef struct packed {
    logic [7:0] hdr;
    logic [7:0] single;
    logic       rd_mode;
  } rsp_meta_t;
endpackage

// File: rtl/rsp_rdbuf.sv
module rsp_rdbuf #(
  parameter int LEN_W = 6,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [LEN_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LEN_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << LEN_W;

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, read-first, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rsp_meta.sv
module rsp_meta
  import rsp_framer_pkg::*;
#(
  parameter int         LEN_W    = 6,
  parameter logic [7:0] ACK_CODE = 8'hAC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             is_write,
  input  logic             err,
  input  logic [7:0]       err_code,
  input  logic [LEN_W-1:0] len,
  output rsp_meta_t        meta,
  output logic [LEN_W-1:0] last
);
  localparam int PAD_W = 7 - LEN_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      last <= '0;
    end else if (done) begin
      meta.hdr     <= {err, {PAD_W{1'b0}}, (err ? {LEN_W{1'b0}} : len)};
      meta.single  <= err ? err_code : ACK_CODE;
      meta.rd_mode <= !err && !is_write;
      last         <= len;
    end
  end
endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
  import rsp_framer_pkg::*;
#(
  parameter int         LEN_W     = 6,
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done,
  input  logic             start,
  input  logic             tx_req,
  input  rsp_meta_t        meta,
  input  logic [LEN_W-1:0] last,
  input  logic [7:0]       mem_q,
  output logic [LEN_W-1:0] rd_addr,
  output logic [7:0]       tx_byte,
  output logic             flush,
  output logic             ready
);
  phase_t           phase;
  logic [LEN_W-1:0] ptr;
  logic             serve;
  logic             advance;

  assign serve   = tx_req && ready && !done;
  assign advance = serve && (phase == PH_BODY) && meta.rd_mode && (ptr != last);

  // look one entry ahead so back-to-back requests see fresh buffer data
  always_comb begin
    if (done)         rd_addr = '0;
    else if (advance) rd_addr = ptr + 1'b1;
    else              rd_addr = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_SPENT;
      ptr     <= '0;
      tx_byte <= IDLE_BYTE;
      flush   <= 1'b0;
      ready   <= 1'b0;
    end else begin
      flush <= done;
      ptr   <= rd_addr;
      if (done) begin
        ready   <= 1'b1;
        phase   <= PH_HDR;
        tx_byte <= IDLE_BYTE;
      end else begin
        if (start) ready <= 1'b0;
        if (tx_req) begin
          if (!ready) begin
            tx_byte <= IDLE_BYTE;
          end else begin
            unique case (phase)
              PH_HDR: begin
                tx_byte <= meta.hdr;
                phase   <= PH_BODY;
              end
              PH_BODY: begin
                if (meta.rd_mode) begin
                  tx_byte <= mem_q;
                  if (ptr == last) phase <= PH_SPENT;
                end else begin
                  tx_byte <= meta.single;
                  phase   <= PH_SPENT;
                end
              end
              default: tx_byte <= IDLE_BYTE;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/rsp_framer.sv
module rsp_framer
  import rsp_framer_pkg::*;
#(
  parameter int         LEN_W     = 6,
  parameter logic [7:0] ACK_CODE  = 8'hAC,
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eng_done,
  input  logic             eng_is_write,
  input  logic             eng_err,
  input  logic [7:0]       eng_err_code,
  input  logic [LEN_W-1:0] eng_len,
  input  logic             buf_we,
  input  logic [LEN_W-1:0] buf_addr,
  input  logic [7:0]       buf_wdata,
  input  logic             start_seen,
  input  logic             tx_req,
  output logic [7:0]       tx_byte,
  output logic             tx_flush,
  output logic             rsp_ready
);
  rsp_meta_t        meta;
  logic [LEN_W-1:0] last;
  logic [LEN_W-1:0] rd_addr;
  logic [7:0]       mem_q;

  rsp_rdbuf #(.LEN_W(LEN_W), .DW(8)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr (rd_addr),
    .rdata (mem_q)
  );

  rsp_meta #(.LEN_W(LEN_W), .ACK_CODE(ACK_CODE)) u_meta (
    .clk      (clk),
    .rst      (rst),
    .done     (eng_done),
    .is_write (eng_is_write),
    .err      (eng_err),
    .err_code (eng_err_code),
    .len      (eng_len),
    .meta     (meta),
    .last     (last)
  );

  rsp_seq #(.LEN_W(LEN_W), .IDLE_BYTE(IDLE_BYTE)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .done    (eng_done),
    .start   (start_seen),
    .tx_req  (tx_req),
    .meta    (meta),
    .last    (last),
    .mem_q   (mem_q),
    .rd_addr (rd_addr),
    .tx_byte (tx_byte),
    .flush   (tx_flush),
    .ready   (rsp_ready)
  );
endmodule

// File: rtl/rsp_framer_chk.sv
module rsp_framer_chk #(
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input logic       clk,
  input logic       rst,
  input logic       eng_done,
  input logic       start_seen,
  input logic       tx_req,
  input logic [7:0] tx_byte,
  input logic       tx_flush,
  input logic       rsp_ready
);
  // R7
  flush_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> tx_flush);

  // R7
  flush_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    !eng_done |=> !tx_flush);

  // R8
  ready_arm_chk: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> rsp_ready);

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (start_seen && !eng_done) |=> !rsp_ready);

  // R9
  byte_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_req && !eng_done) |=> $stable(tx_byte));

  // R6
  idle_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !rsp_ready && !eng_done) |=> (tx_byte == IDLE_BYTE));
endmodule

bind rsp_framer rsp_framer_chk #(.IDLE_BYTE(IDLE_BYTE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .eng_done   (eng_done),
  .start_seen (start_seen),
  .tx_req     (tx_req),
  .tx_byte    (tx_byte),
  .tx_flush   (tx_flush),
  .rsp_ready  (rsp_ready)
);

// File: tb/test_rsp_framer.sv
`timescale 1ns/1ps
module test_rsp_framer;
  localparam int LEN_W = 6;
  localparam int DEPTH = 1 << LEN_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             eng_done = 0, eng_is_write = 0, eng_err = 0;
  logic [7:0]       eng_err_code = 0;
  logic [LEN_W-1:0] eng_len = 0;
  logic             buf_we = 0;
  logic [LEN_W-1:0] buf_addr = 0;
  logic [7:0]       buf_wdata = 0;
  logic             start_seen = 0, tx_req = 0;
  logic [7:0]       tx_byte;
  logic             tx_flush, rsp_ready;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rsp_framer i_rsp_framer (.*);

  // behavioural reference model
  logic [7:0] ref_mem [DEPTH];
  logic [7:0] q [$];
  string      tq [$];
  logic [7:0] m_byte = 8'hFF;
  logic       m_ready = 0, m_flush = 0;
  string      m_btag = "R11";

  always @(posedge clk) begin
    if (rst) begin
      m_byte = 8'hFF; m_ready = 0; m_flush = 0; m_btag = "R11";
      q.delete(); tq.delete();
    end else begin
      m_flush = eng_done;
      if (eng_done) begin
        q.delete(); tq.delete();
        if (eng_err) begin
          q.push_back(8'h80);         tq.push_back("R1 R3");
          q.push_back(eng_err_code);  tq.push_back("R3");
        end else begin
          q.push_back({2'b00, eng_len}); tq.push_back("R1 R2");
          if (eng_is_write) begin
            q.push_back(8'hAC); tq.push_back("R4");
          end else begin
            for (int i = 0; i <= int'(eng_len); i++) begin
              q.push_back(ref_mem[i]); tq.push_back("R5 R10");
            end
          end
        end
        m_ready = 1; m_byte = 8'hFF; m_btag = "R9";
      end else begin
        if (tx_req) begin
          if (m_ready && q.size() > 0) begin
            m_byte = q.pop_front(); m_btag = tq.pop_front();
          end else begin
            m_byte = 8'hFF; m_btag = "R6";
          end
        end else begin
          m_btag = "R9";
        end
        if (start_seen) begin
          m_ready = 0; q.delete(); tq.delete();
        end
      end
      if (buf_we) ref_mem[buf_addr] = buf_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      n_cmp++;
      if (tx_byte !== 8'hFF || rsp_ready !== 1'b0 || tx_flush !== 1'b0) begin
        n_bad++;
        $display("FAIL R11 reset: byte=%h ready=%b flush=%b expected ff 0 0",
                 tx_byte, rsp_ready, tx_flush);
      end
    end else begin
      n_cmp += 3;
      if (tx_byte !== m_byte) begin
        n_bad++;
        $display("FAIL %s tx_byte=%h expected %h at %0t", m_btag, tx_byte, m_byte, $time);
      end
      if (rsp_ready !== m_ready) begin
        n_bad++;
        $display("FAIL R8 rsp_ready=%b expected %b at %0t", rsp_ready, m_ready, $time);
      end
      if (tx_flush !== m_flush) begin
        n_bad++;
        $display("FAIL R7 tx_flush=%b expected %b at %0t", tx_flush, m_flush, $time);
      end
    end
  end

  // each task starts just after a falling edge and spends whole cycles
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fill(int seed);
    for (int a = 0; a < DEPTH; a++) begin
      buf_we = 1; buf_addr = LEN_W'(a); buf_wdata = 8'(a * 7 + seed);
      @(negedge clk);
    end
    buf_we = 0;
  endtask

  task automatic finish_op(logic wr, logic er, logic [7:0] code, logic [LEN_W-1:0] len,
                           logic with_start);
    eng_done = 1; eng_is_write = wr; eng_err = er; eng_err_code = code; eng_len = len;
    start_seen = with_start;
    @(negedge clk);
    eng_done = 0; start_seen = 0;
  endtask

  task automatic reqs(int n, int gap);
    for (int k = 0; k < n; k++) begin
      tx_req = 1; @(negedge clk); tx_req = 0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic start_pulse(logic with_req);
    start_seen = 1; tx_req = with_req; @(negedge clk);
    start_seen = 0; tx_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R6: requests before anything is armed
    reqs(3, 0);
    fill(3);
    // R1 R2 R5 R10: 4-byte read, back to back, then R6 overrun
    finish_op(0, 0, 8'h00, 6'd3, 0); idle(1);
    reqs(8, 0);
    start_pulse(0);
    // R4: write ack
    finish_op(1, 0, 8'h00, 6'd5, 0); reqs(4, 1);
    // R3: error forces length one, code returned
    start_pulse(0);
    finish_op(0, 1, 8'hE2, 6'd17, 0); reqs(3, 0);
    start_pulse(1);
    finish_op(1, 1, 8'hE1, 6'd63, 0); reqs(3, 2);
    // R5: full 64-byte read, every cycle
    start_pulse(0);
    finish_op(0, 0, 8'h00, 6'd63, 0); reqs(67, 0);
    // R5: single byte read
    start_pulse(0);
    finish_op(0, 0, 8'h00, 6'd0, 0); reqs(3, 0);
    // R7 R8: new completion mid-read, and completion with start
    start_pulse(0); fill(91);
    finish_op(0, 0, 8'h00, 6'd10, 0); reqs(4, 0);
    finish_op(0, 0, 8'h00, 6'd2, 0); reqs(5, 0);
    finish_op(1, 0, 8'h00, 6'd1, 1); reqs(3, 0);
    start_pulse(1); reqs(2, 0);
    // mixed pseudo-random traffic
    for (int c = 0; c < 6000; c++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lf[4:0] == 5'd0) begin
        finish_op(lf[5], lf[6] & lf[7], lf[15:8], lf[13:8], lf[9] & lf[11] & lf[14]);
      end else if (lf[4:0] == 5'd1) begin
        start_pulse(lf[8]);
      end else if (!m_ready && lf[4:2] == 3'd5) begin
        buf_we = 1; buf_addr = lf[15:10]; buf_wdata = lf[11:4];
        @(negedge clk); buf_we = 0;
      end else begin
        tx_req = lf[8] | lf[9]; @(negedge clk); tx_req = 0;
      end
    end
    idle(3);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule